// File: doc/BRIEF.md
# Banked data memory address generator

This block forms the 12-bit effective address into a 4096-byte data space split into sixteen 256-byte banks, for a small 8-bit processor whose instructions carry only an 8-bit file operand. The operand is combined with one of two bank sources, chosen by a one-bit flag in the instruction. With the flag set, the current bank register supplies the upper four address bits. With the flag clear, a split window that ignores the bank register is used. The lower half of the operand range reaches general RAM at the bottom of bank 0, and the upper half reaches the special-function registers at the top of bank 15.

The block holds the 4-bit bank register. A load-bank instruction writes that register from a literal through a synchronous load port. The block also provides a direct path for the two-word register-to-register move, whose words each carry a full 12-bit address. On that path the incoming address goes straight to the output, and a copy is registered so that the first word's address is still available while the second word is handled. The effective address is combinational, so the register file can be read in the same cycle.

Top module: `bank_addr_gen`

## Requirements
- R1: After a synchronous reset, the bank register reads 0 and the held direct address reads 0x000.
- R2: In banked mode (path_sel=0) with use_bank=1, ea equals the bank register in bits 11:8 and file_op in bits 7:0.
- R3: In banked mode with use_bank=0 and file_op in 0x00–0x7F, ea equals file_op zero-extended (0x000–0x07F), whatever the bank register holds.
- R4: In banked mode with use_bank=0 and file_op in 0x80–0xFF, ea equals 0xF00 | file_op (0xF80–0xFFF), whatever the bank register holds.
- R5: When bank_ld=1 at a clock edge, the bank register takes bank_lit bits 3:0 at that edge, and bits 7:4 of the literal have no effect.
- R6: When bank_ld=0 at a clock edge, the bank register keeps its value.
- R7: In direct mode (path_sel=1), ea equals dir_addr in the same cycle, independent of file_op, use_bank and the bank register.
- R8: When path_sel=1 at a clock edge, mv_hold takes dir_addr at that edge. Otherwise mv_hold keeps its value.
- R9: A run of direct-mode cycles with bank_ld=0 leaves the bank register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| path_sel | input | 1 | 0 selects the banked operand path, 1 selects the direct 12-bit path |
| file_op | input | 8 | File operand from the instruction word |
| use_bank | input | 1 | 1 takes the bank from the bank register, 0 uses the split window |
| bank_ld | input | 1 | Load strobe for the bank register |
| bank_lit | input | 8 | Literal for the bank load; only bits 3:0 are used |
| dir_addr | input | 12 | Full address for the direct path |
| ea | output | 12 | Effective data-memory address |
| bank_out | output | 4 | Current bank register value |
| mv_hold | output | 12 | Direct address registered from the last direct-mode cycle |

## Verification
The assertions check every cycle that both halves of the split window land in the correct bank, that banked addressing places the bank register in the upper bits, and that the direct path passes its address through. They also check that the bank register and the move holding register load on their strobe and hold otherwise. Only the bench's scenarios can show the reset values and that literal bits above bit 3 are discarded. The bench also shows the 0x7F/0x80 boundary under a nonzero bank and that a long direct-mode run leaves the bank intact. Beyond this, the bench compares a reference model against a long random mix of loads, modes and operands.

// File: rtl/bank_addr_pkg.sv
package bank_addr_pkg;
    localparam int OP_W   = 8;
    localparam int BANK_W = 4;
    localparam int LIT_W  = 8;
    localparam int ADDR_W = OP_W + BANK_W;

    typedef logic [OP_W-1:0]   op_t;
    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [LIT_W-1:0]  lit_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic {
        PATH_BANKED = 1'b0,
        PATH_DIRECT = 1'b1
    } path_e;

    // Split window: lower operand half to bank 0, upper half to the last bank.
    function automatic addr_t split_window(op_t op);
        bank_t top;
        top = op[OP_W-1] ? {BANK_W{1'b1}} : {BANK_W{1'b0}};
        return {top, op};
    endfunction
endpackage

// File: rtl/bank_select_reg.sv
module bank_select_reg
    import bank_addr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld,
    input  lit_t  lit,
    output bank_t bank_q
);
    always_ff @(posedge clk) begin
        if (rst)
            bank_q <= '0;
        else if (ld)
            bank_q <= lit[BANK_W-1:0];
    end

    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (rst)
        ld |=> bank_q == $past(lit[BANK_W-1:0])); // R5
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(bank_q)); // R6
endmodule

// File: rtl/banked_map.sv
module banked_map
    import bank_addr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  op_t   op,
    input  logic  use_bank,
    input  bank_t bank,
    output addr_t addr
);
    always_comb begin
        if (use_bank)
            addr = {bank, op};
        else
            addr = split_window(op);
    end

    AST_SPLIT_LOW: assert property (@(posedge clk) disable iff (rst)
        (!use_bank && !op[OP_W-1]) |-> (addr[ADDR_W-1:OP_W] == '0 && addr[OP_W-1:0] == op)); // R3
    AST_SPLIT_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!use_bank && op[OP_W-1]) |-> (addr[ADDR_W-1:OP_W] == '1 && addr[OP_W-1:0] == op)); // R4
    AST_BANKED_UPPER: assert property (@(posedge clk) disable iff (rst)
        use_bank |-> (addr[ADDR_W-1:OP_W] == bank && addr[OP_W-1:0] == op)); // R2
endmodule

// File: rtl/move_addr_hold.sv
module move_addr_hold
    import bank_addr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cap,
    input  addr_t d,
    output addr_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (cap)
            q <= d;
    end

    AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        cap |=> q == $past(d)); // R8
    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(q)); // R8
endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen
    import bank_addr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        path_sel,
    input  logic [7:0]  file_op,
    input  logic        use_bank,
    input  logic        bank_ld,
    input  logic [7:0]  bank_lit,
    input  logic [11:0] dir_addr,
    output logic [11:0] ea,
    output logic [3:0]  bank_out,
    output logic [11:0] mv_hold
);
    path_e path;
    bank_t bank_q;
    addr_t banked_addr;

    assign path = path_e'(path_sel);

    bank_select_reg u_bank (
        .clk    (clk),
        .rst    (rst),
        .ld     (bank_ld),
        .lit    (bank_lit),
        .bank_q (bank_q)
    );

    banked_map u_map (
        .clk      (clk),
        .rst      (rst),
        .op       (file_op),
        .use_bank (use_bank),
        .bank     (bank_q),
        .addr     (banked_addr)
    );

    move_addr_hold u_hold (
        .clk (clk),
        .rst (rst),
        .cap (path == PATH_DIRECT),
        .d   (dir_addr),
        .q   (mv_hold)
    );

    always_comb begin
        unique case (path)
            PATH_DIRECT: ea = dir_addr;
            default:     ea = banked_addr;
        endcase
    end

    assign bank_out = bank_q;

    AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (rst)
        path_sel |-> ea == dir_addr); // R7
    AST_DIRECT_KEEPS_BANK: assert property (@(posedge clk) disable iff (rst)
        (path_sel && !bank_ld) |=> $stable(bank_out)); // R9
endmodule

// File: tb/bank_addr_gen_test.sv
module bank_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        path_sel;
    logic [7:0]  file_op;
    logic        use_bank;
    logic        bank_ld;
    logic [7:0]  bank_lit;
    logic [11:0] dir_addr;
    logic [11:0] ea;
    logic [3:0]  bank_out;
    logic [11:0] mv_hold;

    int checks = 0;
    int fails  = 0;
    logic [3:0]  m_bank;
    logic [11:0] m_hold;

    always #2.5 clk = ~clk;

    bank_addr_gen uut (
        .clk(clk), .rst(rst), .path_sel(path_sel), .file_op(file_op),
        .use_bank(use_bank), .bank_ld(bank_ld), .bank_lit(bank_lit),
        .dir_addr(dir_addr), .ea(ea), .bank_out(bank_out), .mv_hold(mv_hold)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_ea(logic ps, logic ub, logic [7:0] op,
                                           logic [3:0] bk, logic [11:0] da);
        if (ps) return da;
        if (ub) return {bk, op};
        if (op < 8'h80) return {4'h0, op};
        return {4'hF, op};
    endfunction

    function automatic string ea_tag(logic ps, logic ub, logic [7:0] op);
        if (ps) return "R7";
        if (ub) return "R2";
        return (op < 8'h80) ? "R3" : "R4";
    endfunction

    // Drive one cycle at the falling edge, check ea, then advance the model.
    task automatic step(input logic ps, input logic ub, input logic [7:0] op,
                        input logic ld, input logic [7:0] lit, input logic [11:0] da);
        logic [11:0] e;
        @(negedge clk);
        path_sel = ps; use_bank = ub; file_op = op;
        bank_ld = ld; bank_lit = lit; dir_addr = da;
        #1;
        e = exp_ea(ps, ub, op, m_bank, da);
        check(ea == e, ea_tag(ps, ub, op), int'(ea), int'(e));
        if (ld) m_bank = lit[3:0];
        if (ps) m_hold = da;
    endtask

    task automatic check_state(input logic last_ld);
        @(negedge clk);
        check(bank_out == m_bank, last_ld ? "R5" : "R6", int'(bank_out), int'(m_bank));
        check(mv_hold == m_hold, "R8", int'(mv_hold), int'(m_hold));
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; path_sel = 0; file_op = 0; use_bank = 0;
        bank_ld = 0; bank_lit = 0; dir_addr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_bank = 4'h0; m_hold = 12'h000;
        // R1: reset state
        check(bank_out == 4'h0, "R1", int'(bank_out), 0);
        check(mv_hold == 12'h000, "R1", int'(mv_hold), 0);
        step(1'b0, 1'b1, 8'h34, 1'b0, 8'h00, 12'h000);   // R2 with bank 0

        // R5: upper literal bits discarded
        step(1'b0, 1'b1, 8'h00, 1'b1, 8'hF5, 12'h000);
        check_state(1'b1);
        check(bank_out == 4'h5, "R5", int'(bank_out), 5);
        // R3/R4 boundary with a nonzero bank
        step(1'b0, 1'b0, 8'h7F, 1'b0, 8'h00, 12'h000);
        step(1'b0, 1'b0, 8'h80, 1'b0, 8'h00, 12'h000);
        step(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 12'h000);
        step(1'b0, 1'b0, 8'hFF, 1'b0, 8'h00, 12'h000);
        step(1'b0, 1'b1, 8'hA7, 1'b0, 8'h00, 12'h000);   // R2 -> 0x5A7

        // R7/R8/R9: two-word move, bank unaffected
        step(1'b1, 1'b1, 8'h11, 1'b0, 8'h00, 12'h125);
        step(1'b1, 1'b0, 8'h22, 1'b0, 8'h00, 12'h140);
        check_state(1'b0);
        for (int i = 0; i < 6; i++)
            step(1'b1, 1'b1, 8'($urandom), 1'b0, 8'($urandom), 12'($urandom));
        @(negedge clk);
        check(bank_out == 4'h5, "R9", int'(bank_out), 5);
        check(mv_hold == m_hold, "R8", int'(mv_hold), int'(m_hold));

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic ld;
            ld = ($urandom % 4) == 0;
            step(1'(($urandom % 3) == 0), 1'($urandom), 8'($urandom),
                 ld, 8'($urandom), 12'($urandom));
            check_state(ld);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule